// File: doc/BRIEF.md
# Four-Contestant Quiz Buzzer Controller

This block decides which of four contestants pressed a button first. The first press is held. Every later press is locked out until the host clears the round. When a winner is held, a tone-enable output rises for a fixed number of seconds. An answer countdown then starts from 100 seconds and is stepped by an external one-second tick. When the count reaches zero, the tone sounds again and the count stays at zero.

The winner is given as a binary code together with a valid flag. A scanned four-digit seven-segment display shows two things: the contestant number (1 to 4) and the remaining seconds as three decimal digits. The display is blank while no winner is held. Buttons reach the block already debounced. The tone-enable output gates an external tone generator.

Top module: `quiz_buzzer_top`

## Requirements
- R1: After reset, `winner_valid` and `tone_en` are 0 and `seg` is all zeros.
- R2: A press on `btn[i]` while no winner is held makes `winner_valid` 1 and `winner_code` equal to i (contestant i+1) on the next clock.
- R3: When several buttons are high in the same cycle with no winner held, the lowest index wins.
- R4: While a winner is held and `clear` is low, button presses do not change `winner_code` or `winner_valid`.
- R5: `clear` drops `winner_valid`, stops the tone and sets the countdown back to 100. A press in the same cycle as `clear` is not latched.
- R6: `tone_en` is high from the clock after a latch until TONE_SECS ticks of `sec_tick` have been counted.
- R7: Each `sec_tick` after the latch cycle lowers the remaining time by one. A tick in the latch cycle itself does not count.
- R8: The tick that takes the time from 1 to 0 raises `tone_en` again for TONE_SECS ticks. The time then stays at 0.
- R9: `digit_sel` is one-hot and active-high. It rotates bit 0 → 1 → 2 → 3 → 0, and each digit is held for SCAN_DIV clocks. Digit 0 shows the winner number, digit 1 the hundreds, digit 2 the tens and digit 3 the units of the remaining time.
- R10: `seg` is active-high with a on bit 6 down to g on bit 0. The patterns for 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F and 7B (hex). `seg` is all zeros while no winner is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Host clear that starts a new round |
| sec_tick | input | 1 | One-cycle pulse once per second |
| btn | input | 4 | Contestant buttons, active-high, bit i is contestant i+1 |
| winner_code | output | 2 | Binary index of the held winner |
| winner_valid | output | 1 | A winner is held |
| tone_en | output | 1 | Enable for the external tone generator |
| digit_sel | output | 4 | One-hot digit select |
| seg | output | 7 | Segments a..g on bits 6..0, active-high |

## Verification
Two events can land in the same cycle: the latch of a press and a second tick. The bench provokes this by raising a button and `sec_tick` in the same cycle. It then checks two things: the display still reads 100 afterwards, and the tone lasts the full TONE_SECS further ticks. The bench also raises `clear` and a button together, and checks that no winner appears and the display stays blank.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int NUM_DIGITS = 4;

  // Active-high segment pattern, a on bit 6 .. g on bit 0.
  function automatic logic [6:0] seg_pattern(input logic [3:0] val);
    logic [6:0] p;
    case (val)
      4'd0:    p = 7'h7E;
      4'd1:    p = 7'h30;
      4'd2:    p = 7'h6D;
      4'd3:    p = 7'h79;
      4'd4:    p = 7'h33;
      4'd5:    p = 7'h5B;
      4'd6:    p = 7'h5F;
      4'd7:    p = 7'h70;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h7B;
      default: p = 7'h00;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/quiz_lockout.sv
module quiz_lockout #(
  parameter int N_PLAYERS = 4,
  localparam int CODE_W = $clog2(N_PLAYERS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic [N_PLAYERS-1:0] btn,
  output logic [CODE_W-1:0]    code,
  output logic                 valid,
  output logic                 grant
);
  logic [CODE_W-1:0] code_q, code_d, pick;
  logic              valid_q, valid_d;

  always_comb begin
    pick = '0;
    for (int i = N_PLAYERS - 1; i >= 0; i--) begin
      if (btn[i]) pick = CODE_W'(i);
    end
  end

  assign grant = !valid_q && !clear && (|btn);

  always_comb begin
    code_d  = code_q;
    valid_d = valid_q;
    if (clear) begin
      valid_d = 1'b0;
    end else if (grant) begin
      valid_d = 1'b1;
      code_d  = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= valid_d;
    end
  end

  assign code  = code_q;
  assign valid = valid_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !clear |=> valid_q && $stable(code_q)); // R4
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !valid_q); // R5
  AST_PRESS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q && !clear && (|btn) |=> valid_q); // R2
endmodule

// File: rtl/quiz_countdown.sv
module quiz_countdown #(
  parameter int COUNT_START = 100,
  parameter int TONE_SECS   = 1,
  localparam int TW     = $clog2(COUNT_START + 1),
  localparam int TONE_W = $clog2(TONE_SECS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          grant,
  input  logic          sec_tick,
  output logic [TW-1:0] remaining,
  output logic          tone_en
);
  logic [TW-1:0]     rem_q, rem_d;
  logic [TONE_W-1:0] tone_q, tone_d;
  logic              run_q, run_d;

  always_comb begin
    rem_d  = rem_q;
    tone_d = tone_q;
    run_d  = run_q;
    if (clear) begin
      rem_d  = TW'(COUNT_START);
      tone_d = '0;
      run_d  = 1'b0;
    end else begin
      if (sec_tick && tone_q != '0) tone_d = tone_q - TONE_W'(1);
      if (grant) begin
        run_d  = 1'b1;
        tone_d = TONE_W'(TONE_SECS);
      end else if (run_q && sec_tick && rem_q != '0) begin
        rem_d = rem_q - TW'(1);
        if (rem_q == TW'(1)) tone_d = TONE_W'(TONE_SECS);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= TW'(COUNT_START);
      tone_q <= '0;
      run_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      tone_q <= tone_d;
      run_q  <= run_d;
    end
  end

  assign remaining = rem_q;
  assign tone_en   = (tone_q != '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q == '0 && !clear |=> rem_q == '0); // R8
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && sec_tick && rem_q != '0 && !clear && !grant |=> rem_q == $past(rem_q) - TW'(1)); // R7
  AST_TONE_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !clear |=> tone_en); // R6
  AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> rem_q == TW'(COUNT_START) && !tone_en); // R5
endmodule

// File: rtl/quiz_display.sv
module quiz_display
  import quiz_pkg::*;
#(
  parameter int N_PLAYERS = 4,
  parameter int COUNT_START = 100,
  parameter int SCAN_DIV = 16,
  localparam int CODE_W = $clog2(N_PLAYERS),
  localparam int TW     = $clog2(COUNT_START + 1),
  localparam int DIV_W  = $clog2(SCAN_DIV),
  localparam int IDX_W  = $clog2(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid,
  input  logic [CODE_W-1:0]     code,
  input  logic [TW-1:0]         remaining,
  output logic [NUM_DIGITS-1:0] digit_sel,
  output logic [6:0]            seg
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [3:0]       val;
  int               r;

  always_comb begin
    idx_d = idx_q;
    if (div_q == DIV_W'(SCAN_DIV - 1)) begin
      div_d = '0;
      idx_d = idx_q + IDX_W'(1);
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      idx_q <= '0;
    end else begin
      div_q <= div_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    r = int'(remaining);
    case (idx_q)
      2'd0:    val = 4'(int'(code) + 1);
      2'd1:    val = 4'((r / 100) % 10);
      2'd2:    val = 4'((r / 10) % 10);
      default: val = 4'(r % 10);
    endcase
  end

  assign digit_sel = NUM_DIGITS'(1) << idx_q;
  assign seg       = valid ? seg_pattern(val) : 7'h00;

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(digit_sel) == 1); // R9
endmodule

// File: rtl/quiz_buzzer_top.sv
module quiz_buzzer_top #(
  parameter int COUNT_START = 100,
  parameter int TONE_SECS   = 1,
  parameter int SCAN_DIV    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sec_tick,
  input  logic [3:0] btn,
  output logic [1:0] winner_code,
  output logic       winner_valid,
  output logic       tone_en,
  output logic [3:0] digit_sel,
  output logic [6:0] seg
);
  localparam int N_PLAYERS = 4;
  localparam int TW = $clog2(COUNT_START + 1);

  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          grant;
  logic [TW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  quiz_lockout #(.N_PLAYERS(N_PLAYERS)) u_lock (
    .clk(clk), .rst_n(rst_s), .clear(clear), .btn(btn),
    .code(winner_code), .valid(winner_valid), .grant(grant)
  );

  quiz_countdown #(.COUNT_START(COUNT_START), .TONE_SECS(TONE_SECS)) u_count (
    .clk(clk), .rst_n(rst_s), .clear(clear), .grant(grant),
    .sec_tick(sec_tick), .remaining(remaining), .tone_en(tone_en)
  );

  quiz_display #(.N_PLAYERS(N_PLAYERS), .COUNT_START(COUNT_START),
                 .SCAN_DIV(SCAN_DIV)) u_disp (
    .clk(clk), .rst_n(rst_s), .valid(winner_valid), .code(winner_code),
    .remaining(remaining), .digit_sel(digit_sel), .seg(seg)
  );

  AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    !winner_valid |-> seg == 7'h00); // R10
endmodule

// File: tb/tb_quiz_buzzer_top.sv
module tb_quiz_buzzer_top;
  localparam int SCAN = 4;
  localparam int TONE = 2;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, sec_tick = 1'b0;
  logic [3:0] btn = '0;
  logic [1:0] winner_code;
  logic winner_valid, tone_en;
  logic [3:0] digit_sel;
  logic [6:0] seg;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quiz_buzzer_top #(.COUNT_START(100), .TONE_SECS(TONE), .SCAN_DIV(SCAN)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sec_tick(sec_tick), .btn(btn),
    .winner_code(winner_code), .winner_valid(winner_valid), .tone_en(tone_en),
    .digit_sel(digit_sel), .seg(seg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int seg2dig(input logic [6:0] s);
    case (s)
      7'h7E: return 0; 7'h30: return 1; 7'h6D: return 2; 7'h79: return 3;
      7'h33: return 4; 7'h5B: return 5; 7'h5F: return 6; 7'h70: return 7;
      7'h7F: return 8; 7'h7B: return 9;
      default: return -1;
    endcase
  endfunction

  // Reads one full scan; returns winner digit and time (-1 if any digit unreadable).
  task automatic read_disp(output int win, output int tim);
    int d[4];
    for (int k = 0; k < 4; k++) d[k] = -100;
    for (int c = 0; c < 4 * SCAN + 2; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (digit_sel == 4'(1 << k)) d[k] = seg2dig(seg);
    end
    win = d[0];
    if (d[1] < 0 || d[2] < 0 || d[3] < 0) tim = -1;
    else tim = d[1] * 100 + d[2] * 10 + d[3];
  endtask

  task automatic press(input logic [3:0] p);
    @(negedge clk) btn = p;
    @(negedge clk) btn = '0;
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w, t, run, prev_sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 valid", winner_valid, 0);
    chk("R1 tone", tone_en, 0);
    for (int c = 0; c < 2 * SCAN; c++) begin
      @(negedge clk);
      chk("R1 seg blank", seg, 0);
    end

    // R2 sweep over single contestants, display contents R9 R10
    for (int i = 0; i < 4; i++) begin
      do_clear();
      press(4'(1 << i));
      chk("R2 valid", winner_valid, 1);
      chk("R2 code", winner_code, i);
      chk("R6 tone after latch", tone_en, 1);
      read_disp(w, t);
      chk("R9 winner digit", w, i + 1);
      chk("R10 time digits", t, 100);
    end

    // R3 every simultaneous pattern
    for (int p = 1; p < 16; p++) begin
      int exp_i;
      exp_i = 0;
      for (int b = 3; b >= 0; b--) if (p[b]) exp_i = b;
      do_clear();
      press(4'(p));
      chk("R3 lowest wins", winner_code, exp_i);
    end

    // R4 lockout
    do_clear();
    press(4'b0100);
    for (int p = 1; p < 16; p++) begin
      press(4'(p));
      chk("R4 code held", winner_code, 2);
      chk("R4 valid held", winner_valid, 1);
    end

    // R5 clear beats same-cycle press
    @(negedge clk) begin clear = 1'b1; btn = 4'b0001; end
    @(negedge clk) begin clear = 1'b0; btn = 4'b0000; end
    chk("R5 valid dropped", winner_valid, 0);
    chk("R5 tone off", tone_en, 0);
    chk("R5 seg blank", seg, 0);

    // R7 latch with tick in the same cycle
    @(negedge clk) begin btn = 4'b1000; sec_tick = 1'b1; end
    @(negedge clk) begin btn = 4'b0000; sec_tick = 1'b0; end
    chk("R2 code 3", winner_code, 3);
    chk("R6 tone on", tone_en, 1);
    read_disp(w, t);
    chk("R7 latch tick ignored", t, 100);
    tick();
    chk("R6 tone still on", tone_en, 1);
    tick();
    chk("R6 tone ends after TONE ticks", tone_en, 0);
    read_disp(w, t);
    chk("R7 two ticks", t, 98);
    for (int s = 98; s > 1; s--) begin
      tick();
      if (s == 51 || s == 10) begin
        read_disp(w, t);
        chk("R7 mid count", t, s - 1);
      end
    end
    read_disp(w, t);
    chk("R7 at one", t, 1);
    chk("R8 no tone before zero", tone_en, 0);
    tick();
    chk("R8 tone at zero", tone_en, 1);
    tick();
    chk("R8 tone held", tone_en, 1);
    tick();
    chk("R8 tone ends", tone_en, 0);
    tick();
    read_disp(w, t);
    chk("R8 holds at zero", t, 0);
    chk("R9 winner digit 4", w, 4);

    // R5 clear reloads countdown
    do_clear();
    chk("R5 cleared", winner_valid, 0);
    press(4'b0010);
    read_disp(w, t);
    chk("R5 reload 100", t, 100);

    // R9 scan timing
    @(negedge clk);
    prev_sel = digit_sel;
    while (digit_sel == 4'(prev_sel)) @(negedge clk);
    for (int r = 0; r < 5; r++) begin
      int cur;
      cur = digit_sel;
      chk("R9 rotate", cur, ((prev_sel << 1) | (prev_sel >> 3)) & 15);
      run = 0;
      while (digit_sel == 4'(cur)) begin
        run++;
        @(negedge clk);
      end
      chk("R9 hold length", run, SCAN);
      prev_sel = cur;
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule